// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block sits between a host that issues single-word read and write requests and the command pins of a single-data-rate SDRAM. It brings the device out of reset, programs its mode register, and then serves each host request as a closed-page access: the row is opened, one column is read or written with auto-precharge, and the bank is idle again when the host is told the access is over. The data bus and byte masks are handled elsewhere; this block owns only the clock-enable, command, bank and address pins.

A free-running interval timer raises a refresh demand. The sequencer serves that demand the next time it is idle, ahead of any host request, so a host may see its request wait for one refresh period. The host raises `req_valid` with a word address and a direction and holds all three until `done` pulses. Every minimum spacing between commands is a parameter counted in clock cycles.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While `rst_n` is low, `mem_cke` is 0, the pins carry a no-operation, `busy` is 1 and `done` is 0; from the first rising edge after reset release `mem_cke` is 1 and stays 1.
- R2: Commands on {`mem_cs_n`,`mem_ras_n`,`mem_cas_n`,`mem_we_n`} are: no-operation 0111, row open 0011, column read 0101, column write 0100, precharge 0010, auto-refresh 0001, mode register load 0000.
- R3: Counting rising edges after reset release, precharge-all (address bit 10 set, all other address and bank bits 0) appears after edge INIT_WAIT; auto-refresh follows T_RP cycles later, a second auto-refresh T_RFC cycles after that, and the mode register load T_RFC cycles after the second refresh.
- R4: The mode register load drives bank 0 and an address word with CAS_LAT in bits 6:4 and every other bit 0 (burst length one, sequential order); no row open occurs until T_RSC cycles after it, even if a request is already waiting.
- R5: The host word address is split, most significant first, into bank (BANK_W bits), row (ROW_W bits) and column (COL_W bits); a row open drives the row zero-extended on the address pins and the bank on the bank pins.
- R6: Exactly T_RCD cycles after the row open, a column read (`req_write`=0) or write (`req_write`=1) to the same bank drives the column on the low address bits with bit 10 set and all other bits 0.
- R7: `done` pulses for one cycle exactly T_RP cycles after the column command; `busy` is 1 from the row open until the cycle before `done` and is 0 in the `done` cycle.
- R8: A refresh demand arises every REF_INTERVAL cycles after reset release; when idle with a demand outstanding the sequencer issues auto-refresh (with `busy` high) before any host row open, and issues nothing else for T_RFC cycles.
- R9: In the cycle `done` is high no new request is taken, so a `req_valid` still held for one cycle after `done` opens no row.
- R10: Every cycle without a scheduled command drives the no-operation with address and bank pins at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request, held until `done` |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | BANK_W+ROW_W+COL_W | Word address {bank, row, column} |
| busy | output | 1 | Sequencer is initialising, refreshing or serving an access |
| done | output | 1 | One-cycle pulse at the end of an access |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BANK_W | Bank select |
| mem_a | output | A_W | Multiplexed row/column/mode address |

## Verification
A refresh demand and a host request can both be ready at the same idle decision, and the refresh must take that slot while the request waits intact for the next one. The bench sets a short refresh interval and issues requests with varied idle gaps, so demands fall before, during and exactly at request arrival, including right after a `done` with the request held. A behavioural model schedules every expected command, address and handshake value per cycle from the timing parameters and compares them with the pins on every clock, so a refresh stolen by a request, or a request lost behind a refresh, shows up as a mismatch in that very cycle.

// File: rtl/sdr_seq_pkg.sv
`timescale 1ns/1ps
package sdr_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } cmd_e;

    typedef enum logic [3:0] {
        PH_PWRUP,
        PH_PRE_INIT,
        PH_REF_INIT1,
        PH_REF_INIT2,
        PH_MODE,
        PH_IDLE,
        PH_ACT,
        PH_ACC,
        PH_REF_RUN
    } phase_e;

    function automatic int dmax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/sdr_addr_map.sv
`timescale 1ns/1ps
module sdr_addr_map #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    localparam int HADDR_W = BANK_W + ROW_W + COL_W
) (
    input  logic [HADDR_W-1:0] haddr,
    output logic [BANK_W-1:0]  bank,
    output logic [ROW_W-1:0]   row,
    output logic [COL_W-1:0]   col
);

    // Bank in the top bits, then row, then column in the low bits.
    assign bank = haddr[HADDR_W-1 -: BANK_W];
    assign row  = haddr[COL_W +: ROW_W];
    assign col  = haddr[COL_W-1:0];

endmodule

// File: rtl/sdr_ref_timer.sv
`timescale 1ns/1ps
module sdr_ref_timer #(
    parameter int INTERVAL = 780,
    localparam int RW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);

    logic [RW-1:0] cnt_d, cnt_q;
    logic          pend_d, pend_q;
    logic          tick;

    always_comb begin
        tick   = (cnt_q == '0);
        cnt_d  = tick ? RW'(INTERVAL - 1) : cnt_q - RW'(1);
        pend_d = pend_q;
        if (tick) begin
            pend_d = 1'b1;
        end else if (ack) begin
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= RW'(INTERVAL - 1);
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    assign pending = pend_q;

endmodule

// File: rtl/sdr_cmd_pins.sv
`timescale 1ns/1ps
module sdr_cmd_pins
    import sdr_seq_pkg::*;
(
    input  cmd_e cmd,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);

    logic [3:0] pins;

    always_comb begin
        case (cmd)
            CMD_ACT: pins = 4'b0011;
            CMD_RD:  pins = 4'b0101;
            CMD_WR:  pins = 4'b0100;
            CMD_PRE: pins = 4'b0010;
            CMD_REF: pins = 4'b0001;
            CMD_MRS: pins = 4'b0000;
            default: pins = 4'b0111;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = pins;

endmodule

// File: rtl/sdram_cmd_seq.sv
`timescale 1ns/1ps
module sdram_cmd_seq
    import sdr_seq_pkg::*;
#(
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 12,
    parameter int COL_W        = 9,
    parameter int A_W          = 13,
    parameter int INIT_WAIT    = 100,
    parameter int T_RCD        = 2,
    parameter int T_RP         = 2,
    parameter int T_RSC        = 2,
    parameter int T_RFC        = 7,
    parameter int REF_INTERVAL = 780,
    parameter int CAS_LAT      = 2,
    localparam int HADDR_W     = BANK_W + ROW_W + COL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [HADDR_W-1:0] req_addr,
    output logic               busy,
    output logic               done,
    output logic               mem_cke,
    output logic               mem_cs_n,
    output logic               mem_ras_n,
    output logic               mem_cas_n,
    output logic               mem_we_n,
    output logic [BANK_W-1:0]  mem_ba,
    output logic [A_W-1:0]     mem_a
);

    localparam int AP_BIT = 10;
    localparam int MAXD   = dmax(dmax(INIT_WAIT, T_RFC), dmax(dmax(T_RCD, T_RP), T_RSC));
    localparam int CNT_W  = $clog2(MAXD + 1);
    localparam logic [A_W-1:0] AP_MASK   = A_W'(1) << AP_BIT;
    localparam logic [A_W-1:0] MODE_WORD = A_W'(CAS_LAT) << 4;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        cmd_e                cmd;
        logic [BANK_W-1:0]   ba;
        logic [A_W-1:0]      a;
        logic [BANK_W-1:0]   bank;
        logic [ROW_W-1:0]    row;
        logic [COL_W-1:0]    col;
        logic                wr;
        logic                busy;
        logic                done;
        logic                cke;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [BANK_W-1:0] map_bank;
    logic [ROW_W-1:0]  map_row;
    logic [COL_W-1:0]  map_col;
    logic              ref_pending;
    logic              ref_ack;

    sdr_addr_map #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W)
    ) addr_map_i (
        .haddr (req_addr),
        .bank  (map_bank),
        .row   (map_row),
        .col   (map_col)
    );

    sdr_ref_timer #(
        .INTERVAL (REF_INTERVAL)
    ) ref_timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    sdr_cmd_pins cmd_pins_i (
        .cmd   (seq_q.cmd),
        .cs_n  (mem_cs_n),
        .ras_n (mem_ras_n),
        .cas_n (mem_cas_n),
        .we_n  (mem_we_n)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.cmd  = CMD_NOP;
        seq_d.a    = '0;
        seq_d.ba   = '0;
        seq_d.done = 1'b0;
        seq_d.cke  = 1'b1;
        ref_ack    = 1'b0;

        if (seq_q.cnt != '0) begin
            seq_d.cnt = seq_q.cnt - CNT_W'(1);
        end else begin
            case (seq_q.phase)
                PH_PWRUP: begin
                    seq_d.cmd   = CMD_PRE;
                    seq_d.a     = AP_MASK;
                    seq_d.phase = PH_PRE_INIT;
                    seq_d.cnt   = CNT_W'(T_RP - 1);
                end
                PH_PRE_INIT: begin
                    seq_d.cmd   = CMD_REF;
                    seq_d.phase = PH_REF_INIT1;
                    seq_d.cnt   = CNT_W'(T_RFC - 1);
                end
                PH_REF_INIT1: begin
                    seq_d.cmd   = CMD_REF;
                    seq_d.phase = PH_REF_INIT2;
                    seq_d.cnt   = CNT_W'(T_RFC - 1);
                end
                PH_REF_INIT2: begin
                    seq_d.cmd   = CMD_MRS;
                    seq_d.a     = MODE_WORD;
                    seq_d.phase = PH_MODE;
                    seq_d.cnt   = CNT_W'(T_RSC - 1);
                end
                PH_MODE: begin
                    seq_d.phase = PH_IDLE;
                end
                PH_IDLE: begin
                    if (ref_pending) begin
                        seq_d.cmd   = CMD_REF;
                        seq_d.phase = PH_REF_RUN;
                        seq_d.cnt   = CNT_W'(T_RFC - 1);
                        ref_ack     = 1'b1;
                    end else if (req_valid && !seq_q.done) begin
                        seq_d.cmd   = CMD_ACT;
                        seq_d.a     = A_W'(map_row);
                        seq_d.ba    = map_bank;
                        seq_d.bank  = map_bank;
                        seq_d.row   = map_row;
                        seq_d.col   = map_col;
                        seq_d.wr    = req_write;
                        seq_d.phase = PH_ACT;
                        seq_d.cnt   = CNT_W'(T_RCD - 1);
                    end
                end
                PH_ACT: begin
                    seq_d.cmd   = seq_q.wr ? CMD_WR : CMD_RD;
                    seq_d.a     = A_W'(seq_q.col) | AP_MASK;
                    seq_d.ba    = seq_q.bank;
                    seq_d.phase = PH_ACC;
                    seq_d.cnt   = CNT_W'(T_RP - 1);
                end
                PH_ACC: begin
                    seq_d.done  = 1'b1;
                    seq_d.phase = PH_IDLE;
                end
                PH_REF_RUN: begin
                    seq_d.phase = PH_IDLE;
                end
                default: begin
                    seq_d.phase = PH_IDLE;
                end
            endcase
        end

        seq_d.busy = (seq_d.phase != PH_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.phase <= PH_PWRUP;
            seq_q.cnt   <= CNT_W'(INIT_WAIT - 1);
            seq_q.cmd   <= CMD_NOP;
            seq_q.busy  <= 1'b1;
            seq_q.cke   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy    = seq_q.busy;
    assign done    = seq_q.done;
    assign mem_cke = seq_q.cke;
    assign mem_ba  = seq_q.ba;
    assign mem_a   = seq_q.a;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
`timescale 1ns/1ps
module sdram_cmd_seq_chk #(
    parameter int A_W     = 13,
    parameter int CAS_LAT = 2,
    parameter int T_RCD   = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           mem_cke,
    input logic           mem_cs_n,
    input logic           mem_ras_n,
    input logic           mem_cas_n,
    input logic           mem_we_n,
    input logic [A_W-1:0] mem_a
);

    localparam logic [A_W-1:0] MODE_VAL = A_W'(CAS_LAT) << 4;

    logic [3:0] pins;
    logic       is_nop, is_act, is_col, is_pre, is_ref, is_mrs;

    assign pins   = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    assign is_nop = (pins == 4'b0111);
    assign is_act = (pins == 4'b0011);
    assign is_col = (pins == 4'b0101) || (pins == 4'b0100);
    assign is_pre = (pins == 4'b0010);
    assign is_ref = (pins == 4'b0001);
    assign is_mrs = (pins == 4'b0000);

    // R1
    cke_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_cke) |-> mem_cke);

    // R3
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> mem_a[10]);

    // R4
    mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (mem_a == MODE_VAL));

    // R6
    col_autopre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> mem_a[10]);

    // R6
    act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && (T_RCD > 1)) |=> is_nop);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    ref_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> busy);

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
    .A_W     (A_W),
    .CAS_LAT (CAS_LAT),
    .T_RCD   (T_RCD)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .mem_cke   (mem_cke),
    .mem_cs_n  (mem_cs_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_a     (mem_a)
);

// File: tb/sdram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb_top;

    localparam int INIT_WAIT = 12;
    localparam int T_RCD     = 3;
    localparam int T_RP      = 2;
    localparam int T_RSC     = 2;
    localparam int T_RFC     = 5;
    localparam int RI        = 47;
    localparam int CL        = 3;

    localparam int K_PRE  = 1;
    localparam int K_REF  = 2;
    localparam int K_MRS  = 3;
    localparam int K_ACC  = 4;
    localparam int K_DONE = 5;
    localparam int K_IDLE = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [22:0] req_addr = '0;
    logic        busy, done, mem_cke;
    logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [1:0]  mem_ba;
    logic [12:0] mem_a;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    sdram_cmd_seq #(
        .INIT_WAIT    (INIT_WAIT),
        .T_RCD        (T_RCD),
        .T_RP         (T_RP),
        .T_RSC        (T_RSC),
        .T_RFC        (T_RFC),
        .REF_INTERVAL (RI),
        .CAS_LAT      (CL)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .busy      (busy),
        .done      (done),
        .mem_cke   (mem_cke),
        .mem_cs_n  (mem_cs_n),
        .mem_ras_n (mem_ras_n),
        .mem_cas_n (mem_cas_n),
        .mem_we_n  (mem_we_n),
        .mem_ba    (mem_ba),
        .mem_a     (mem_a)
    );

    // Behavioural reference: a queue of scheduled steps with absolute due edges.
    int         k;
    int         due;
    int         plan[$];
    bit         pend;
    bit         prev_done;
    int         h_bank, h_row, h_col;
    bit         h_wr;
    logic [3:0] e_pins;
    logic [12:0] e_a;
    logic [1:0] e_ba;
    bit         e_done, e_busy, e_cke;
    string      tag;

    task automatic model_reset();
        k = 0; due = INIT_WAIT; pend = 0; prev_done = 0;
        plan = {K_PRE, K_REF, K_REF, K_MRS, K_IDLE};
        e_pins = 4'b0111; e_a = '0; e_ba = '0;
        e_done = 0; e_busy = 1; e_cke = 0; tag = "R1";
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit ack;
            k++;
            ack = 0;
            e_pins = 4'b0111; e_a = '0; e_ba = '0; e_done = 0; e_cke = 1;
            tag = "R10";
            if (plan.size() != 0) begin
                if (k == due) begin
                    int step;
                    step = plan.pop_front();
                    case (step)
                        K_PRE:  begin e_pins = 4'b0010; e_a = 13'h400; due = k + T_RP; tag = "R3"; end
                        K_REF:  begin e_pins = 4'b0001; due = k + T_RFC; tag = "R3"; end
                        K_MRS:  begin e_pins = 4'b0000; e_a = 13'(CL * 16); due = k + T_RSC; tag = "R4"; end
                        K_ACC:  begin
                            e_pins = h_wr ? 4'b0100 : 4'b0101;
                            e_a = 13'(h_col + 1024); e_ba = 2'(h_bank);
                            due = k + T_RP; tag = "R6";
                        end
                        K_DONE: begin e_done = 1; tag = "R7"; end
                        default: tag = "R4";
                    endcase
                end else begin
                    tag = "R10";
                end
            end else begin
                if (pend) begin
                    e_pins = 4'b0001; due = k + T_RFC; plan.push_back(K_IDLE);
                    ack = 1; tag = "R8";
                end else if (req_valid && !prev_done) begin
                    h_bank = int'(req_addr) / (1 << 21);
                    h_row  = (int'(req_addr) / 512) % 4096;
                    h_col  = int'(req_addr) % 512;
                    h_wr   = req_write;
                    e_pins = 4'b0011; e_a = 13'(h_row); e_ba = 2'(h_bank);
                    due = k + T_RCD; plan.push_back(K_ACC); plan.push_back(K_DONE);
                    tag = "R5";
                end else if (req_valid && prev_done) begin
                    tag = "R9";
                end
            end
            if (k % RI == 0) pend = 1;
            else if (ack) pend = 0;
            e_busy = (plan.size() != 0);
            prev_done = e_done;
        end
    end

    task automatic check1(string t, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s at edge %0d: actual %0h expected %0h", t, what, k, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !ended) begin
            check1({tag, "/R2"}, "cmd pins", int'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}), int'(e_pins));
            check1(tag, "address", int'(mem_a), int'(e_a));
            check1(tag, "bank", int'(mem_ba), int'(e_ba));
            check1("R7", "busy", int'(busy), int'(e_busy));
            check1("R7", "done", int'(done), int'(e_done));
            check1("R1", "cke", int'(mem_cke), int'(e_cke));
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            nerr++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    task automatic host_access(logic [22:0] addr, logic wr, bit linger);
        req_addr  = addr;
        req_write = wr;
        req_valid = 1'b1;
        do @(negedge clk); while (!done);
        if (linger) @(negedge clk);   // R9: request still held after done
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check1("R1", "reset cke", int'(mem_cke), 0);
        check1("R1/R2", "reset cmd", int'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}), 7);
        check1("R1", "reset busy", int'(busy), 1);
        check1("R1", "reset done", int'(done), 0);
        rst_n = 1'b1;
        // R4: request waiting from the start must not open a row before the mode load
        host_access(23'h000000, 1'b1, 1'b0);
        host_access(23'h7FFFFF, 1'b0, 1'b0);
        host_access(23'h2AAAAA, 1'b1, 1'b1);
        host_access(23'h555555, 1'b0, 1'b0);
        for (int i = 0; i < 300; i++) begin
            int gap;
            gap = int'($urandom_range(0, 6));
            repeat (gap) @(negedge clk);
            host_access(23'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0));
        end
        repeat (3 * RI) @(negedge clk);
        finish_run();
    end

endmodule